// File: doc/BRIEF.md
# MSI-X Vector Table and Pending-Bit Controller

This block keeps the per-vector interrupt state of a PCIe-style function. For each vector it stores a table entry. The entry holds a 64-bit message address, a 32-bit message data word and a control word whose bit 0 masks the vector. The block also keeps one pending bit per vector, plus a function-level enable bit and a function-level mask bit. Software reaches all of this state through one register port with three regions: the capability, the table and the pending bits.

The device raises interrupts by pulsing a vector's trigger input. Every accepted trigger sets that vector's pending bit. A sequential scanner walks the vector index, one vector per cycle. When it reaches a vector that is pending and unmasked while the function is enabled and not masked, it places that vector's address and data on a valid/ready message output. The pending bit clears only when the message is accepted.

Because of this scheme, a vector that is masked or blocked by the function mask keeps its request as a pending bit. Clearing either mask makes the scanner replay the request. Triggers that arrive while the output is stalled are never lost.

Top module: `msix_ctrl`

## Requirements
- R1: After reset every vector's control word reads 1 (masked), the other table words read 0, all pending bits read 0, and the capability field reads 0 (enable and function mask both clear).
- R2: Table region, byte offset 16*v + k. The dwords are address low (k=0), address high (k=4), data (k=8) and control (k=12). A write of length 4 stores reg_wdata[31:0] in the dword at k. A write of length 8 at k=0 or k=8 stores [31:0] in that dword and [63:32] in the next dword. Any other length, and a length-8 write with offset bit 2 set, leaves the table unchanged. A read returns the 8-byte-aligned pair that contains the offset: the lower dword in [31:0] and the upper dword in [63:32].
- R3: Capability region. Only a write with length 2 at offset 2 updates the control bits: enable from bit 15 and function mask from bit 14. Any other write is ignored. A read returns these bits in the same positions, with all other bits 0.
- R4: While enable is 0, triggers are ignored (no pending bit is set) and no message is launched.
- R5: When the function is enabled and unmasked, the vector is unmasked, the output is ready and nothing else is pending, a trigger produces one message within NVEC+2 cycles. The message carries the vector's table address and data, and the pending bit ends clear.
- R6: A trigger on an enabled function whose vector mask or function mask is set sends no message and sets the vector's pending bit.
- R7: When the function mask goes from 1 to 0, every vector with its pending bit set and its own mask clear sends one message and has its pending bit cleared. Vectors that are still masked stay pending.
- R8: When a table write clears a pending vector's mask bit while the function mask is clear, that vector sends one message and its pending bit clears.
- R9: Pending region. Vector n is bit n mod 64 of the 64-bit word read at byte offset 8*(n/64). Writes to this region have no effect.
- R10: msg_valid, msg_addr, msg_data and msg_vec hold steady until msg_ready is seen. A pending bit is cleared only by the acceptance of its message. Triggers that arrive during a stall become pending and are sent later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Region: 0 capability, 1 table, 2 pending bits |
| reg_off | input | OFFW | Byte offset within the region |
| reg_len | input | 4 | Access length in bytes |
| reg_wdata | input | 64 | Write data, little-endian |
| reg_rdata | output | 64 | Read data for the addressed location |
| trig | input | NVEC | Per-vector interrupt trigger pulses |
| msg_valid | output | 1 | Message available |
| msg_ready | input | 1 | Message accepted by the consumer |
| msg_addr | output | 64 | Message address |
| msg_data | output | 32 | Message data |
| msg_vec | output | VW | Vector that produced the message |

## Verification
The bench builds the block with NVEC=4, which makes the table 16 dwords and the pending bits one word. With so few vectors, every one of the 15 non-empty trigger patterns can be swept. Each vector's expected message count can be checked exactly, and every vector can be visited while masked, while blocked by the function mask and while the output is stalled. Expected addresses and data are simple arithmetic functions of the vector number.

// File: rtl/msix_ctrl.sv
module msix_ctrl #(
  parameter int NVEC = 16,
  localparam int OFFW = $clog2(NVEC * 16),
  localparam int VW = $clog2(NVEC),
  localparam int NPW = (NVEC + 63) / 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic [1:0]      reg_sel,
  input  logic [OFFW-1:0] reg_off,
  input  logic [3:0]      reg_len,
  input  logic [63:0]     reg_wdata,
  output logic [63:0]     reg_rdata,
  input  logic [NVEC-1:0] trig,
  output logic            msg_valid,
  input  logic            msg_ready,
  output logic [63:0]     msg_addr,
  output logic [31:0]     msg_data,
  output logic [VW-1:0]   msg_vec
);

  logic [31:0]     tab [NVEC*4];
  logic [NVEC-1:0] pend, vmask, done;
  logic            en, fmask;
  logic [VW-1:0]   idx, nxt;
  logic [NPW*64-1:0] ppad;

  wire [OFFW-3:0] dwi = reg_off[OFFW-1:2];
  wire [OFFW-3:0] dlo = {dwi[OFFW-3:1], 1'b0};
  wire [OFFW-3:0] dhi = {dwi[OFFW-3:1], 1'b1};
  wire tw  = reg_wr && reg_sel == 2'd1;
  wire w4  = tw && reg_len == 4'd4;
  wire w8  = tw && reg_len == 4'd8 && !reg_off[2];
  wire cw  = reg_wr && reg_sel == 2'd0 && reg_off == OFFW'(2) && reg_len == 4'd2;

  for (genvar g = 0; g < NVEC; g++) begin : g_mask
    assign vmask[g] = tab[g*4+3][0];
  end

  wire elig = en && !fmask && pend[idx] && !vmask[idx];
  assign nxt = (idx == VW'(NVEC - 1)) ? '0 : idx + 1'b1;

  always_comb begin
    done = '0;
    if (msg_valid && msg_ready) done[msg_vec] = 1'b1;
    ppad = '0;
    ppad[NVEC-1:0] = pend;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < NVEC*4; i++) tab[i] <= (i % 4 == 3) ? 32'd1 : 32'd0;
    end else begin
      if (w4 || w8) tab[dwi] <= reg_wdata[31:0];
      if (w8) tab[dhi] <= reg_wdata[63:32];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en <= 1'b0;
      fmask <= 1'b0;
      pend <= '0;
    end else begin
      if (cw) begin
        en <= reg_wdata[15];
        fmask <= reg_wdata[14];
      end
      pend <= (pend & ~done) | (en ? trig : '0);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      idx <= '0;
      msg_valid <= 1'b0;
      msg_addr <= '0;
      msg_data <= '0;
      msg_vec <= '0;
    end else if (msg_valid) begin
      if (msg_ready) begin
        msg_valid <= 1'b0;
        idx <= nxt;
      end
    end else if (elig) begin
      msg_valid <= 1'b1;
      msg_vec <= idx;
      msg_addr <= {tab[{idx, 2'd1}], tab[{idx, 2'd0}]};
      msg_data <= tab[{idx, 2'd2}];
    end else begin
      idx <= nxt;
    end

  always_comb begin
    reg_rdata = '0;
    case (reg_sel)
      2'd0: reg_rdata = {48'd0, en, fmask, 14'd0};
      2'd1: reg_rdata = {tab[dhi], tab[dlo]};
      2'd2: for (int w = 0; w < NPW; w++)
              if (int'(reg_off[OFFW-1:3]) == w) reg_rdata = ppad[w*64 +: 64];
      default: reg_rdata = '0;
    endcase
  end

  AST_HOLD_MSG: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_addr) && $stable(msg_data) && $stable(msg_vec)); // R10
  AST_CLEAR_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(pend) & ~pend) != '0) |-> $past(msg_valid && msg_ready)); // R10
  AST_LAUNCH_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msg_valid) |-> $past(pend[idx])); // R7
  AST_LAUNCH_ALLOWED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msg_valid) |-> $past(en && !fmask && !vmask[idx])); // R6
  AST_TRIG_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    en && (trig != '0) |=> ((pend & $past(trig)) == $past(trig))); // R6
  AST_OFF_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
    !en && pend == '0 |=> pend == '0); // R4

endmodule

// File: tb/msix_ctrl_tb.sv
`timescale 1ns/1ps
module msix_ctrl_tb_top;
  localparam int NVEC = 4;
  localparam int OFFW = 6;

  logic clk = 0, rst_n = 0, reg_wr = 0, msg_ready = 1;
  logic [1:0] reg_sel = 0;
  logic [OFFW-1:0] reg_off = 0;
  logic [3:0] reg_len = 0;
  logic [63:0] reg_wdata = 0, reg_rdata, msg_addr;
  logic [NVEC-1:0] trig = 0;
  logic msg_valid;
  logic [31:0] msg_data;
  logic [1:0] msg_vec;

  int total = 0, bad = 0;
  int cnt [NVEC];
  int snap [NVEC];

  msix_ctrl #(.NVEC(NVEC)) dut_i (.*);

  always #4 clk = ~clk;

  function automatic logic [63:0] eaddr(int v);
    return 64'hFEE0_0000_0000_1000 + 64'(v) * 64'h10 + (64'(v) << 32);
  endfunction
  function automatic logic [31:0] edata(int v);
    return 32'h4000 + 32'(v) * 3;
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] s, int off, int len, logic [63:0] d);
    @(negedge clk);
    reg_sel = s; reg_off = OFFW'(off); reg_len = 4'(len); reg_wdata = d; reg_wr = 1;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(logic [1:0] s, int off, output logic [63:0] d);
    @(negedge clk);
    reg_sel = s; reg_off = OFFW'(off);
    #1 d = reg_rdata;
  endtask

  task automatic fire(logic [NVEC-1:0] p);
    @(negedge clk); trig = p;
    @(negedge clk); trig = '0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic take_snap();
    for (int v = 0; v < NVEC; v++) snap[v] = cnt[v];
  endtask

  task automatic chk_delta(logic [NVEC-1:0] p, string req);
    for (int v = 0; v < NVEC; v++)
      chk(cnt[v] - snap[v] == int'(p[v]), req, 64'(cnt[v] - snap[v]), 64'(p[v]));
  endtask

  always @(negedge clk)
    if (rst_n && msg_valid && msg_ready) begin
      cnt[msg_vec]++;
      chk(msg_addr == eaddr(msg_vec) && msg_data == edata(msg_vec), "R5 msg",
          msg_addr ^ 64'(msg_data), eaddr(msg_vec) ^ 64'(edata(msg_vec)));
    end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0] d, a0, a1;
    for (int v = 0; v < NVEC; v++) cnt[v] = 0;
    idle(3);
    rst_n = 1;
    // R1 reset state
    rd(0, 2, d); chk(d == 0, "R1 cap", d, 0);
    rd(2, 0, d); chk(d == 0, "R1 pba", d, 0);
    for (int v = 0; v < NVEC; v++) begin
      rd(1, v*16 + 8, d); chk(d == 64'h1_0000_0000, "R1 ctrl", d, 64'h1_0000_0000);
      rd(1, v*16, d); chk(d == 0, "R1 addr", d, 0);
    end
    // R2 table programming and layout
    for (int v = 0; v < NVEC; v++) begin
      wr(1, v*16, 8, {32'h0, eaddr(v)[31:0]});
      wr(1, v*16 + 4, 4, {32'h0, eaddr(v)[63:32]});
      wr(1, v*16 + 8, 4, {32'h0, edata(v)});
      rd(1, v*16 + 4, d); chk(d == eaddr(v), "R2 addr", d, eaddr(v));
      rd(1, v*16 + 12, d); chk(d == {32'd1, edata(v)}, "R2 data/ctrl", d, {32'd1, edata(v)});
    end
    wr(1, 8, 2, 64'hFFFF);
    wr(1, 4, 8, 64'hDEAD_BEEF_DEAD_BEEF);
    wr(1, 16, 1, 64'hFF);
    rd(1, 0, d); chk(d == eaddr(0), "R2 bad len", d, eaddr(0));
    rd(1, 8, d); chk(d == {32'd1, edata(0)}, "R2 bad len", d, {32'd1, edata(0)});
    rd(1, 16, d); chk(d == eaddr(1), "R2 bad len", d, eaddr(1));
    // R3 capability write filtering
    wr(0, 2, 4, 64'hC000);
    wr(0, 0, 2, 64'hC000);
    rd(0, 2, d); chk(d == 0, "R3 ignored", d, 0);
    // R4 disabled: triggers ignored
    for (int v = 0; v < NVEC; v++) wr(1, v*16 + 12, 4, 0);
    take_snap();
    fire('1); idle(20);
    chk_delta('0, "R4 no msg");
    rd(2, 0, d); chk(d == 0, "R4 no pend", d, 0);
    wr(0, 2, 2, 64'h8000);
    rd(0, 2, d); chk(d == 64'h8000, "R3 enable", d, 64'h8000);
    // R5 single vector latency
    for (int v = 0; v < NVEC; v++) begin
      take_snap();
      fire(NVEC'(1) << v); idle(NVEC + 2);
      chk_delta(NVEC'(1) << v, "R5 latency");
    end
    // R5 sweep all trigger patterns
    for (int p = 1; p < (1 << NVEC); p++) begin
      take_snap();
      fire(NVEC'(p)); idle(4 * NVEC);
      chk_delta(NVEC'(p), "R5 sweep");
      rd(2, 0, d); chk(d == 0, "R5 pba clear", d, 0);
    end
    // R6 vector mask
    wr(1, 2*16 + 12, 4, 1);
    take_snap();
    fire(4'b0100); idle(20);
    chk_delta('0, "R6 vmask");
    rd(2, 0, d); chk(d == 64'h4, "R6 pend", d, 64'h4);
    // R6/R7 function mask then release
    wr(0, 2, 2, 64'hC000);
    take_snap();
    fire(4'b1011); idle(20);
    chk_delta('0, "R6 fmask");
    rd(2, 0, d); chk(d == 64'hF, "R6 pend all", d, 64'hF);
    wr(0, 2, 2, 64'h8000); idle(20);
    chk_delta(4'b1011, "R7 replay");
    rd(2, 0, d); chk(d == 64'h4, "R7 masked stays", d, 64'h4);
    // R9 pending region read-only
    wr(2, 0, 8, 64'h0);
    wr(2, 0, 8, '1);
    rd(2, 0, d); chk(d == 64'h4, "R9 read-only", d, 64'h4);
    // R8 vector unmask replay
    take_snap();
    wr(1, 2*16 + 12, 4, 0); idle(20);
    chk_delta(4'b0100, "R8 replay");
    rd(2, 0, d); chk(d == 0, "R8 pend clear", d, 0);
    // R10 stall
    msg_ready = 0;
    take_snap();
    fire('1); idle(10);
    rd(2, 0, d); chk(d == 64'hF, "R10 pend held", d, 64'hF);
    chk(msg_valid == 1, "R10 valid", 64'(msg_valid), 1);
    a0 = msg_addr; idle(3); a1 = msg_addr;
    chk(a0 == a1 && msg_valid, "R10 stable", a1, a0);
    @(negedge clk); msg_ready = 1;
    idle(30);
    chk_delta('1, "R10 drain");
    rd(2, 0, d); chk(d == 0, "R10 pend clear", d, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule